// File: doc/BRIEF.md
# Multi-Processor Interrupt Mask Router

This block collects up to `DATA_W` device interrupt request lines into one shared request vector and distributes them to `NUM_CPU` processors. Each processor owns a full-width enable mask. Its pending vector is the bitwise AND of that mask with the shared requests. A processor's interrupt line is raised while anything is pending for it. Devices raise and drop request bits through set and clear strobes that each carry a bit index.

Software reaches the block over a simple register bus. Each access carries a requester identifier, and that identifier decides what part of one register reads back. A separate real-time-clock flag is set by a tick strobe and cleared by software. The flag drives its own interrupt line, which is meant for processor 0 at a higher priority level. Every bus access gets exactly one registered response, one clock later, carrying read data and an error flag.

Top module: `irq_mask_router`

## Requirements
- R1: After a synchronous active-low reset, every mask, the request vector and the clock flag are zero, all `cpu_irq` bits and `rtc_irq` are low, and `rsp_valid` is low.
- R2: A set strobe makes request bit `dev_set_idx` one and a clear strobe makes bit `dev_clr_idx` zero. Clearing a bit that is already zero changes nothing. A set and a clear of the same index in one cycle leave the bit set.
- R3: Processor c's pending value is always its mask ANDed with the current request vector. It reads back at register index 6+c.
- R4: `cpu_irq[c]` is the OR of processor c's pending bits, registered once. It changes one clock after the edge that altered the mask or the requests.
- R5: A legal write to register index 2+c replaces processor c's whole mask. Enabling a bit that is already requested raises that processor's interrupt, and disabling the last pending bit drops it.
- R6: The register index is the byte offset `bus_addr` shifted right by 6. Index 0 is status, 1 is misc, 2..5 are the masks, 6..9 are pending and 10 is the request vector. A nonzero value in `bus_addr[5:0]` is an error.
- R7: Only `bus_size` = 3 (eight bytes) is legal. Any other size gives `rsp_err` = 1 and read data zero, and changes no state.
- R8: A misc read returns `bus_cpu` in bits [1:0] and the clock flag in bit 4, with all other bits zero.
- R9: A misc write with `bus_wdata[4]` = 1 clears the clock flag. A misc write with bit 4 clear is an error and changes nothing. `rtc_tick` sets the flag, and the tick wins over a clear in the same cycle.
- R10: Status reads as zero. Writes to status, pending or the request vector, and any access to an index above 10, set `rsp_err` and change no state.
- R11: Every cycle with `bus_valid` high is followed, one cycle later, by exactly one cycle of `rsp_valid`. Its `rsp_rdata` reflects the state before the access, and `rsp_rdata` is zero for writes and errors.
- R12: `rtc_irq` equals the clock flag, so it rises the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset from the block base |
| bus_size | input | 2 | log2 of access bytes; only 3 is legal |
| bus_cpu | input | CPU_W | Index of the requesting processor |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Access was illegal |
| rsp_rdata | output | DATA_W | Read data |
| dev_set_valid | input | 1 | Raise a request bit |
| dev_set_idx | input | REQ_IDX_W | Bit to raise |
| dev_clr_valid | input | 1 | Drop a request bit |
| dev_clr_idx | input | REQ_IDX_W | Bit to drop |
| rtc_tick | input | 1 | Set the real-time-clock flag |
| cpu_irq | output | NUM_CPU | Per-processor interrupt level |
| rtc_irq | output | 1 | Real-time-clock interrupt level |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a set and a clear of the same request bit. The other is a clock tick arriving in the cycle that software clears the flag. Both need two independent input sources to line up on one edge. The stimulus drives both strobes from one task before a single edge, so the collision is certain and not left to chance. A narrow-size write to a mask and a write to the request vector are each followed by a read-back. This shows at the ports that an illegal access left the state unchanged.

// File: rtl/irq_router_pkg.sv
// Shared constants for the interrupt mask router: register index layout,
// access size code and field positions. Assumes NUM_CPU is 4 so that the
// index map below stays contiguous (mask block, pending block, request).
package irq_router_pkg;
    localparam int unsigned REG_SHIFT  = 6;   // registers are 64 bytes apart
    localparam int unsigned SIZE_FULL  = 3;   // log2(8 bytes)
    localparam int unsigned IDX_STATUS = 0;
    localparam int unsigned IDX_MISC   = 1;
    localparam int unsigned IDX_MASK0  = 2;
    localparam int unsigned RTC_BIT    = 4;   // clock flag position in misc

    typedef enum logic [2:0] {
        RC_NONE, RC_STATUS, RC_MISC, RC_MASK, RC_PEND, RC_REQ
    } reg_class_e;
endpackage

// File: rtl/irq_req_vector.sv
// Shared request vector. One flop per request line; a clear strobe drops a
// bit, a set strobe raises it, and a set wins over a clear of the same bit.
// Assumes strobes are single-cycle pulses synchronous to clk.
module irq_req_vector #(
    parameter int unsigned REQ_W     = 64,
    parameter int unsigned REQ_IDX_W = $clog2(REQ_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_valid,
    input  logic [REQ_IDX_W-1:0] set_idx,
    input  logic                 clr_valid,
    input  logic [REQ_IDX_W-1:0] clr_idx,
    output logic [REQ_W-1:0]     req_q
);
    for (genvar b = 0; b < REQ_W; b++) begin : g_bit
        logic set_hit;
        logic clr_hit;
        assign set_hit = set_valid && (set_idx == REQ_IDX_W'(b));
        assign clr_hit = clr_valid && (clr_idx == REQ_IDX_W'(b));

        // Update one request bit; set takes priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)       req_q[b] <= 1'b0;
            else if (set_hit) req_q[b] <= 1'b1;
            else if (clr_hit) req_q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_cpu_slice.sv
// Per-processor state: enable mask, derived pending vector and registered
// interrupt level. The pending vector is combinational so a read always
// sees mask AND requests of the current cycle.
module irq_cpu_slice #(
    parameter int unsigned REQ_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [REQ_W-1:0] mask_wdata,
    input  logic [REQ_W-1:0] req_vec,
    output logic [REQ_W-1:0] mask_q,
    output logic [REQ_W-1:0] pend,
    output logic             irq_q
);
    // Hold the processor's enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // Pending is the enabled subset of the requests.
    assign pend = mask_q & req_vec;

    // Register the any-pending level toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend;
    end
endmodule

// File: rtl/irq_rtc_flag.sv
// Real-time-clock interrupt flag: a tick sets it, a software clear drops it,
// and a tick in the same cycle as a clear keeps it set.
module irq_rtc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic flag_q
);
    // Set/clear flag with tick priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_q <= 1'b0;
        else if (tick) flag_q <= 1'b1;
        else if (clr)  flag_q <= 1'b0;
    end
endmodule

// File: rtl/irq_bus_decode.sv
// Register bus front end: classifies the register index, checks size,
// alignment and write permission, produces write enables and a registered
// one-cycle response. Assumes DATA_W > RTC_BIT and CPU_W <= RTC_BIT.
module irq_bus_decode
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned CPU_W   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_valid,
    input  logic                           bus_write,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [1:0]                     bus_size,
    input  logic [CPU_W-1:0]               bus_cpu,
    input  logic                           wr_rtc_bit,
    input  logic [NUM_CPU-1:0][DATA_W-1:0] mask_all,
    input  logic [NUM_CPU-1:0][DATA_W-1:0] pend_all,
    input  logic [DATA_W-1:0]              req_vec,
    input  logic                           rtc_flag,
    output logic [NUM_CPU-1:0]             mask_we,
    output logic                           rtc_clr,
    output logic                           rsp_valid,
    output logic                           rsp_err,
    output logic [DATA_W-1:0]              rsp_rdata
);
    localparam int unsigned IDX_W     = ADDR_W - REG_SHIFT;
    localparam int unsigned PEND_BASE = IDX_MASK0 + NUM_CPU;
    localparam int unsigned REQ_INDEX = PEND_BASE + NUM_CPU;

    logic [IDX_W-1:0]    idx;
    logic [REG_SHIFT-1:0] sub;
    logic [NUM_CPU-1:0]  mask_hit;
    logic [NUM_CPU-1:0]  pend_hit;
    reg_class_e          cls;
    logic                err_c;
    logic                wr_ok;
    logic [DATA_W-1:0]   rdata_c;

    assign idx = bus_addr[ADDR_W-1:REG_SHIFT];
    assign sub = bus_addr[REG_SHIFT-1:0];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_hit
        assign mask_hit[c] = (idx == IDX_W'(IDX_MASK0 + c));
        assign pend_hit[c] = (idx == IDX_W'(PEND_BASE + c));
        assign mask_we[c]  = wr_ok && mask_hit[c];
    end

    // Classify the addressed register.
    always_comb begin
        if      (idx == IDX_W'(IDX_STATUS)) cls = RC_STATUS;
        else if (idx == IDX_W'(IDX_MISC))   cls = RC_MISC;
        else if (|mask_hit)                 cls = RC_MASK;
        else if (|pend_hit)                 cls = RC_PEND;
        else if (idx == IDX_W'(REQ_INDEX))  cls = RC_REQ;
        else                                cls = RC_NONE;
    end

    // Decide whether the access is illegal.
    always_comb begin
        err_c = 1'b0;
        if (bus_size != 2'(SIZE_FULL) || sub != '0) err_c = 1'b1;
        unique case (cls)
            RC_NONE:                    err_c = 1'b1;
            RC_STATUS, RC_PEND, RC_REQ: if (bus_write) err_c = 1'b1;
            RC_MISC:                    if (bus_write && !wr_rtc_bit) err_c = 1'b1;
            default: ;
        endcase
    end

    assign wr_ok   = bus_valid && bus_write && !err_c;
    assign rtc_clr = wr_ok && (cls == RC_MISC);

    // Select read data for the addressed register.
    always_comb begin
        rdata_c = '0;
        unique case (cls)
            RC_MISC: begin
                rdata_c[CPU_W-1:0] = bus_cpu;
                rdata_c[RTC_BIT]   = rtc_flag;
            end
            RC_MASK: for (int c = 0; c < NUM_CPU; c++)
                         if (mask_hit[c]) rdata_c = mask_all[c];
            RC_PEND: for (int c = 0; c < NUM_CPU; c++)
                         if (pend_hit[c]) rdata_c = pend_all[c];
            RC_REQ:  rdata_c = req_vec;
            default: rdata_c = '0;
        endcase
    end

    // Register the one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_valid;
            rsp_err   <= bus_valid && err_c;
            rsp_rdata <= (bus_valid && !bus_write && !err_c) ? rdata_c : '0;
        end
    end
endmodule

// File: rtl/irq_mask_router.sv
// Top of the interrupt mask router: one shared request vector, NUM_CPU
// mask/pending slices, a clock flag and the register bus decoder.
// Assumes NUM_CPU >= 2 and DATA_W request lines (one per data bit).
module irq_mask_router
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned CPU_W     = $clog2(NUM_CPU),
    localparam int unsigned REQ_IDX_W = $clog2(DATA_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [CPU_W-1:0]     bus_cpu,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 dev_set_valid,
    input  logic [REQ_IDX_W-1:0] dev_set_idx,
    input  logic                 dev_clr_valid,
    input  logic [REQ_IDX_W-1:0] dev_clr_idx,
    input  logic                 rtc_tick,
    output logic [NUM_CPU-1:0]   cpu_irq,
    output logic                 rtc_irq
);
    logic [DATA_W-1:0]              req_vec;
    logic [NUM_CPU-1:0][DATA_W-1:0] mask_all;
    logic [NUM_CPU-1:0][DATA_W-1:0] pend_all;
    logic [NUM_CPU-1:0]             mask_we;
    logic                           rtc_clr;
    logic                           rtc_flag;

    irq_req_vector #(.REQ_W(DATA_W), .REQ_IDX_W(REQ_IDX_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .set_valid(dev_set_valid), .set_idx(dev_set_idx),
        .clr_valid(dev_clr_valid), .clr_idx(dev_clr_idx),
        .req_q(req_vec)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        irq_cpu_slice #(.REQ_W(DATA_W)) u_slice (
            .clk(clk), .rst_n(rst_n),
            .mask_we(mask_we[c]), .mask_wdata(bus_wdata),
            .req_vec(req_vec),
            .mask_q(mask_all[c]), .pend(pend_all[c]), .irq_q(cpu_irq[c])
        );
    end

    irq_rtc_flag u_rtc (
        .clk(clk), .rst_n(rst_n),
        .tick(rtc_tick), .clr(rtc_clr), .flag_q(rtc_flag)
    );

    irq_bus_decode #(
        .NUM_CPU(NUM_CPU), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CPU_W(CPU_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_cpu(bus_cpu),
        .wr_rtc_bit(bus_wdata[RTC_BIT]),
        .mask_all(mask_all), .pend_all(pend_all), .req_vec(req_vec),
        .rtc_flag(rtc_flag),
        .mask_we(mask_we), .rtc_clr(rtc_clr),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    assign rtc_irq = rtc_flag;
endmodule

// File: rtl/irq_mask_router_chk.sv
// Property checker for irq_mask_router, attached with bind.
module irq_mask_router_chk #(
    parameter int unsigned NUM_CPU   = 4,
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned CPU_W     = 2,
    parameter int unsigned REQ_IDX_W = 6,
    parameter int unsigned ADDR_W    = 12
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_valid,
    input logic                           bus_write,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [1:0]                     bus_size,
    input logic [CPU_W-1:0]               bus_cpu,
    input logic                           rsp_valid,
    input logic                           rsp_err,
    input logic [DATA_W-1:0]              rsp_rdata,
    input logic                           dev_set_valid,
    input logic [REQ_IDX_W-1:0]           dev_set_idx,
    input logic                           dev_clr_valid,
    input logic [REQ_IDX_W-1:0]           dev_clr_idx,
    input logic                           rtc_tick,
    input logic [NUM_CPU-1:0]             cpu_irq,
    input logic                           rtc_irq,
    input logic [DATA_W-1:0]              req_vec,
    input logic [NUM_CPU-1:0][DATA_W-1:0] mask_all
);
    logic misc_rd;
    assign misc_rd = bus_valid && !bus_write && bus_size == 2'd3
                     && bus_addr == ADDR_W'(64);

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        dev_set_valid |=> req_vec[$past(dev_set_idx)]); // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        dev_clr_valid && !(dev_set_valid && dev_set_idx == dev_clr_idx)
        |=> !req_vec[$past(dev_clr_idx)]); // R2

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
        AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> cpu_irq[c] == $past(|(mask_all[c] & req_vec))); // R4
    end

    AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_size != 2'd3 |=> rsp_err && rsp_rdata == '0); // R7

    AST_MISC_ID: assert property (@(posedge clk) disable iff (!rst_n)
        misc_rd |=> rsp_rdata[CPU_W-1:0] == $past(bus_cpu)); // R8

    AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_tick |=> rtc_irq); // R12

    AST_RSP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> rsp_valid); // R11

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !rsp_valid); // R11
endmodule

bind irq_mask_router irq_mask_router_chk #(
    .NUM_CPU(NUM_CPU), .DATA_W(DATA_W), .CPU_W(CPU_W),
    .REQ_IDX_W(REQ_IDX_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_cpu(bus_cpu),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dev_set_valid(dev_set_valid), .dev_set_idx(dev_set_idx),
    .dev_clr_valid(dev_clr_valid), .dev_clr_idx(dev_clr_idx),
    .rtc_tick(rtc_tick), .cpu_irq(cpu_irq), .rtc_irq(rtc_irq),
    .req_vec(req_vec), .mask_all(mask_all)
);

// File: tb/irq_mask_router_bench.sv
module irq_mask_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = '0, bus_cpu = '0;
    logic [63:0] bus_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        dev_set_valid = 1'b0, dev_clr_valid = 1'b0;
    logic [5:0]  dev_set_idx = '0, dev_clr_idx = '0;
    logic        rtc_tick = 1'b0;
    logic [3:0]  cpu_irq;
    logic        rtc_irq;

    int checks = 0;
    int fails  = 0;

    logic [63:0] m_req;
    logic [63:0] m_mask [4];
    logic        m_flag;
    logic        tick_now = 1'b0;

    logic [64:0] exp_q [$];
    string       tag_q [$];
    logic [64:0] exp_e;
    string       exp_t;

    always #4 clk = ~clk;   // 125 MHz

    irq_mask_router u_irq_mask_router (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_cpu(bus_cpu), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dev_set_valid(dev_set_valid), .dev_set_idx(dev_set_idx),
        .dev_clr_valid(dev_clr_valid), .dev_clr_idx(dev_clr_idx),
        .rtc_tick(rtc_tick), .cpu_irq(cpu_irq), .rtc_irq(rtc_irq)
    );

    task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected {err, rdata} from the register map of the requirements.
    function automatic logic [64:0] model_resp(input logic wr, input logic [11:0] a,
        input logic [1:0] sz, input logic [1:0] cpu, input logic [63:0] wd);
        int          idx = int'(a[11:6]);
        logic        e = 1'b0;
        logic [63:0] d = '0;
        if (sz != 2'd3 || a[5:0] != 6'd0) e = 1'b1;
        else if (idx == 0) begin if (wr) e = 1'b1; end
        else if (idx == 1) begin
            if (wr && !wd[4]) e = 1'b1;
            d = {59'd0, m_flag, 2'b00, cpu};
        end
        else if (idx >= 2 && idx <= 5) d = m_mask[idx-2];
        else if (idx >= 6 && idx <= 9) begin if (wr) e = 1'b1; d = m_mask[idx-6] & m_req; end
        else if (idx == 10) begin if (wr) e = 1'b1; d = m_req; end
        else e = 1'b1;
        if (wr || e) d = '0;
        return {e, d};
    endfunction

    // Driver: one access, push expected response, update model.
    task automatic bus_access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                              input logic [1:0] cpu, input logic [63:0] wd, input string tag);
        logic [64:0] r;
        int idx;
        r = model_resp(wr, a, sz, cpu, wd);
        exp_q.push_back(r);
        tag_q.push_back(tag);
        idx = int'(a[11:6]);
        if (wr && !r[64]) begin
            if (idx == 1) m_flag = 1'b0;
            else if (idx >= 2 && idx <= 5) m_mask[idx-2] = wd;
        end
        if (tick_now) m_flag = 1'b1;
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz;
        bus_cpu = cpu; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int idx, input logic [1:0] cpu, input string tag);
        bus_access(1'b0, 12'(idx * 64), 2'd3, cpu, '0, tag);
    endtask

    task automatic wr(input int idx, input logic [63:0] wd, input string tag);
        bus_access(1'b1, 12'(idx * 64), 2'd3, 2'd0, wd, tag);
    endtask

    task automatic dev(input logic se, input logic [5:0] si,
                       input logic ce, input logic [5:0] ci);
        dev_set_valid = se; dev_set_idx = si; dev_clr_valid = ce; dev_clr_idx = ci;
        if (ce) m_req[ci] = 1'b0;
        if (se) m_req[si] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dev_set_valid = 1'b0; dev_clr_valid = 1'b0;
    endtask

    // Wait for the registered level, then compare interrupt outputs.
    task automatic check_irq(input string tag);
        logic [3:0] e;
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < 4; c++) e[c] = |(m_mask[c] & m_req);
        check({tag, " cpu_irq"}, 65'(cpu_irq), 65'(e));
        check({tag, " rtc_irq"}, 65'(rtc_irq), 65'(m_flag));
    endtask

    // Monitor: pop and compare each response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected response", 65'(1), 65'(0));
            end else begin
                exp_e = exp_q.pop_front();
                exp_t = tag_q.pop_front();
                check(exp_t, {rsp_err, rsp_rdata}, exp_e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_req = '0; m_flag = 1'b0;
        for (int c = 0; c < 4; c++) m_mask[c] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 idle rsp_valid", 65'(rsp_valid), 65'(0));
        check_irq("R1 reset");
        rd(10, 2'd0, "R1 request vector after reset");
        rd(1, 2'd0, "R1 misc after reset");

        // Route request 5 to cpu1.
        dev(1'b1, 6'd5, 1'b0, 6'd0);
        wr(3, 64'h20, "R5 mask write cpu1");
        check_irq("R4 R5 enable requested bit");
        rd(7, 2'd0, "R3 pending cpu1");
        rd(10, 2'd3, "R2 request vector bit 5");

        // Wide patterns across processors.
        wr(2, 64'h8000_0000_0000_0001, "R5 mask cpu0");
        wr(4, '1, "R5 mask cpu2");
        dev(1'b1, 6'd63, 1'b0, 6'd0);
        check_irq("R4 bit 63 to cpu0 and cpu2");
        rd(6, 2'd1, "R3 pending cpu0");
        rd(8, 2'd1, "R3 pending cpu2");

        // Clear paths.
        dev(1'b0, 6'd0, 1'b1, 6'd5);
        check_irq("R2 R4 clear drops cpu1");
        dev(1'b0, 6'd0, 1'b1, 6'd7);
        rd(10, 2'd0, "R2 clear of zero bit");
        dev(1'b1, 6'd9, 1'b1, 6'd9);
        rd(10, 2'd0, "R2 set wins same index");

        // Mask disable drops the level.
        wr(4, '0, "R5 mask cpu2 off");
        check_irq("R5 disable drops cpu2");

        // Illegal size leaves state unchanged.
        bus_access(1'b1, 12'(5 * 64), 2'd2, 2'd0, '1, "R7 narrow write");
        bus_access(1'b0, 12'(2 * 64), 2'd0, 2'd0, '0, "R7 narrow read");
        rd(5, 2'd0, "R7 mask cpu3 unchanged");
        check_irq("R7 no irq for cpu3");

        // Misc register and clock flag.
        rd(1, 2'd2, "R8 misc id cpu2");
        tick_now = 1'b1; rtc_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        rtc_tick = 1'b0; tick_now = 1'b0; m_flag = 1'b1;
        check("R12 rtc_irq after tick", 65'(rtc_irq), 65'(1));
        rd(1, 2'd3, "R8 R9 misc flag and id");
        wr(1, 64'h0, "R9 misc write without bit 4");
        rd(1, 2'd1, "R9 flag survives bad write");
        tick_now = 1'b1; rtc_tick = 1'b1;
        wr(1, 64'h10, "R9 clear with tick");
        rtc_tick = 1'b0; tick_now = 1'b0;
        check("R9 tick wins over clear", 65'(rtc_irq), 65'(1));
        wr(1, 64'h10, "R9 clear flag");
        check("R9 flag cleared", 65'(rtc_irq), 65'(0));

        // Map, permissions and alignment.
        rd(0, 2'd0, "R10 status reads zero");
        wr(0, '1, "R10 status write");
        wr(10, '1, "R10 request write");
        wr(6, '1, "R10 pending write");
        rd(10, 2'd0, "R10 request unchanged");
        rd(20, 2'd0, "R10 unmapped index");
        bus_access(1'b0, 12'(2 * 64 + 8), 2'd3, 2'd0, '0, "R6 offset inside slot");
        rd(2, 2'd0, "R6 mask cpu0 at index 2");
        check_irq("R4 final levels");

        @(negedge clk);
        check("R11 all responses seen", 65'(exp_q.size()), 65'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule